// File: doc/BRIEF.md
# Transmit Byte Queue with Byte and Word Write Ports

This block is the transmit data queue that sits between a register-style write path and a serial shifter. Software pushes data through one of two write strobes. The byte strobe enqueues one byte. The word strobe enqueues a full 32-bit word as four bytes. The shifter drains the queue one byte per cycle through a valid/ready handshake.

The block reports how much room is left, counted in bytes, in the upper half of a 32-bit transfer status word. It keeps three sticky interrupt status bits: queue empty, queue full and overrun. Each of these bits is cleared by writing a 1 to it. An enable register selects which of the three bits drive the interrupt line.

When a push asks for more bytes than the queue can hold, the block keeps as many of the lowest-order bytes as fit and drops the rest. It then records an overrun.

Top module: `txq_top`

## Requirements
- R1: While reset is asserted, the block shows this state: `tx_valid` low, `xfer_status` = DEPTH<<16 (0x0040_0000 for the default DEPTH of 64), `int_status` zero, `irq` low, and all interrupt enables cleared.
- R2: A cycle with `wr_byte_we` high and `wr_word_we` low enqueues exactly one byte, `wr_data[7:0]`. Bits [31:8] are discarded.
- R3: A cycle with `wr_word_we` high enqueues the four bytes of `wr_data`, least significant byte first: [7:0], then [15:8], [23:16] and [31:24]. If `wr_byte_we` is also high in that cycle, it is ignored.
- R4: `tx_valid` is high exactly when the queue holds at least one byte. `tx_data` is the oldest byte. Each cycle in which `tx_valid` and `tx_ready` are both high removes one byte, and bytes leave in the order they were accepted.
- R5: `xfer_status[31:16]` equals DEPTH minus the current occupancy and `xfer_status[15:0]` reads zero. Both are updated at the clock edge that ends a push or pop cycle.
- R6: Room for a push is taken from the occupancy at the start of the cycle, so a byte popped in the same cycle frees no room. Only the lowest-order bytes that fit are enqueued and the remainder is dropped. Any dropped byte sets `int_status[11]` (overrun) at that same edge.
- R7: `int_status[9]` (empty) is set at every edge where the occupancy at the start of the cycle is zero. `int_status[10]` (full) is set at every edge where that occupancy is DEPTH. Status bits stay set until cleared.
- R8: A cycle with `int_clr_we` high clears each status bit whose position holds a 1 in `int_clr_data`, and leaves the other bits unchanged. If a set condition occurs in the same cycle, the set wins.
- R9: `int_en_we` loads the enable register from `int_en_data`. `irq` is the OR of (`int_status` AND enable) and changes in the cycle after a write. Only bits 9, 10 and 11 exist: all other status bits read zero and all other enable bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_byte_we | input | 1 | Byte-port write strobe |
| wr_word_we | input | 1 | Word-port write strobe |
| wr_data | input | 32 | Write data shared by both ports |
| int_clr_we | input | 1 | Write strobe for write-1-to-clear of status |
| int_clr_data | input | 32 | Mask of status bits to clear |
| int_en_we | input | 1 | Interrupt enable register write strobe |
| int_en_data | input | 32 | New interrupt enable value |
| xfer_status | output | 32 | Free bytes in [31:16], zero in [15:0] |
| int_status | output | 32 | Sticky status: bit 9 empty, bit 10 full, bit 11 overrun |
| irq | output | 1 | Interrupt line |
| tx_valid | output | 1 | Queue holds a byte for the shifter |
| tx_data | output | 8 | Oldest queued byte |
| tx_ready | input | 1 | Shifter accepts the byte this cycle |

## Verification
The following results show up in the cycle after the clock edge that ends the stimulus cycle: enqueued bytes, the free count, `tx_valid` and `tx_data` after a pop, the overrun bit, status clears, and `irq` after an enable write. The empty and full bits follow the registered occupancy, so they rise one edge after the occupancy itself changes. The bench drives inputs on the falling edge. It advances a byte-queue model by one step, using the occupancy from before that edge, in the same way the block does. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int LANES     = 4;
  localparam int BIT_EMPTY = 9;
  localparam int BIT_FULL  = 10;
  localparam int BIT_OVR   = 11;

  localparam logic [31:0] IRQ_IMPL_MASK =
    (32'd1 << BIT_EMPTY) | (32'd1 << BIT_FULL) | (32'd1 << BIT_OVR);

  // number of bytes of a push that fit in the room left
  function automatic logic [2:0] clip_push(input logic [2:0] req,
                                           input logic [15:0] room);
    if ({13'd0, req} > room) return room[2:0];
    return req;
  endfunction

  // free bytes from depth and occupancy
  function automatic logic [15:0] free_bytes(input logic [15:0] depth,
                                             input logic [15:0] used);
    return depth - used;
  endfunction

  // bytes requested by the two write strobes, word strobe first
  function automatic logic [2:0] push_request(input logic byte_we,
                                              input logic word_we);
    if (word_we) return 3'd4;
    if (byte_we) return 3'd1;
    return 3'd0;
  endfunction

endpackage

// File: rtl/txq_push_sel.sv
module txq_push_sel
  import txq_pkg::*;
(
  input  logic                  wr_byte_we,
  input  logic                  wr_word_we,
  input  logic [31:0]           wr_data,
  input  logic [15:0]           room,
  output logic [LANES-1:0][7:0] lane,
  output logic [2:0]            n_acc,
  output logic                  ovr_evt
);

  logic [2:0] n_req;

  // lane 0 carries the byte port, all lanes carry the word port
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign lane[g] = wr_data[7:0];
    end else begin : g_rest
      assign lane[g] = wr_word_we ? wr_data[8*g +: 8] : 8'h00;
    end
  end

  assign n_req   = push_request(wr_byte_we, wr_word_we);
  assign n_acc   = clip_push(n_req, room);
  assign ovr_evt = (n_req != n_acc);

endmodule

// File: rtl/txq_ring.sv
module txq_ring
  import txq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            push_n,
  input  logic [LANES-1:0][7:0] lane,
  input  logic                  pop,
  output logic [CW-1:0]         used,
  output logic [7:0]            head
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] p,
                                             input logic [2:0] k);
    logic [AW+2:0] s;
    s = {3'b000, p} + {{AW{1'b0}}, k};
    if (s >= (AW+3)'(DEPTH)) s = s - (AW+3)'(DEPTH);
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      wr_ptr <= wrap_add(wr_ptr, push_n);
      if (pop) rd_ptr <= wrap_add(rd_ptr, 3'd1);
      used <= used + CW'(push_n) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < push_n) mem[wrap_add(wr_ptr, 3'(i))] <= lane[i];
    end
  end

  assign head = mem[rd_ptr];

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CW'(DEPTH));

  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (used != '0));

endmodule

// File: rtl/txq_irq_ctl.sv
module txq_irq_ctl
  import txq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] set_vec,
  input  logic        clr_we,
  input  logic [31:0] clr_data,
  input  logic        en_we,
  input  logic [31:0] en_data,
  output logic [31:0] status,
  output logic        irq
);

  logic [31:0] en_q;
  logic [31:0] clr_mask;

  assign clr_mask = clr_we ? clr_data : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      en_q   <= '0;
    end else begin
      status <= ((status & ~clr_mask) | set_vec) & IRQ_IMPL_MASK;
      if (en_we) en_q <= en_data & IRQ_IMPL_MASK;
    end
  end

  assign irq = |(status & en_q);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status & $past(clr_data) & ~$past(set_vec)) == 32'd0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status & $past(status)) == $past(status)));

  p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 32'd0));

endmodule

// File: rtl/txq_top.sv
module txq_top
  import txq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_byte_we,
  input  logic        wr_word_we,
  input  logic [31:0] wr_data,
  input  logic        int_clr_we,
  input  logic [31:0] int_clr_data,
  input  logic        int_en_we,
  input  logic [31:0] int_en_data,
  output logic [31:0] xfer_status,
  output logic [31:0] int_status,
  output logic        irq,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]         used;
  logic [15:0]           room;
  logic [LANES-1:0][7:0] lane;
  logic [2:0]            n_acc;
  logic                  ovr_evt;
  logic                  pop_fire;
  logic                  empty_lvl;
  logic                  full_lvl;
  logic [31:0]           set_vec;

  assign room      = free_bytes(16'(DEPTH), 16'(used));
  assign empty_lvl = (used == '0);
  assign full_lvl  = (used == CW'(DEPTH));
  assign tx_valid  = !empty_lvl;
  assign pop_fire  = tx_valid && tx_ready;

  assign set_vec = (32'(empty_lvl) << BIT_EMPTY)
                 | (32'(full_lvl)  << BIT_FULL)
                 | (32'(ovr_evt)   << BIT_OVR);

  assign xfer_status = {room, 16'h0000};

  txq_push_sel u_push (
    .wr_byte_we (wr_byte_we),
    .wr_word_we (wr_word_we),
    .wr_data    (wr_data),
    .room       (room),
    .lane       (lane),
    .n_acc      (n_acc),
    .ovr_evt    (ovr_evt)
  );

  txq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_n (n_acc),
    .lane   (lane),
    .pop    (pop_fire),
    .used   (used),
    .head   (tx_data)
  );

  txq_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_we   (int_clr_we),
    .clr_data (int_clr_data),
    .en_we    (int_en_we),
    .en_data  (int_en_data),
    .status   (int_status),
    .irq      (irq)
  );

  p_ovr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> int_status[BIT_OVR]);

  p_empty_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty_lvl |=> int_status[BIT_EMPTY]);

  p_free_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_byte_we && !wr_word_we && !pop_fire) |=> $stable(xfer_status));

endmodule

// File: tb/txq_top_bench.sv
`timescale 1ns/1ps
module txq_top_bench;

  localparam int DEPTH = 64;
  localparam logic [31:0] IMPL = 32'h0000_0E00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_byte_we = 1'b0, wr_word_we = 1'b0;
  logic [31:0] wr_data = '0;
  logic        int_clr_we = 1'b0, int_en_we = 1'b0;
  logic [31:0] int_clr_data = '0, int_en_data = '0;
  logic [31:0] xfer_status, int_status;
  logic        irq, tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  byte unsigned mq[$];
  logic [31:0]  m_st = '0;
  logic [31:0]  m_en = '0;

  always #2.5 clk = ~clk;

  txq_top #(.DEPTH(DEPTH)) u_txq_top (
    .clk(clk), .rst_n(rst_n), .wr_byte_we(wr_byte_we), .wr_word_we(wr_word_we),
    .wr_data(wr_data), .int_clr_we(int_clr_we), .int_clr_data(int_clr_data),
    .int_en_we(int_en_we), .int_en_data(int_en_data), .xfer_status(xfer_status),
    .int_status(int_status), .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready)
  );

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_free();
    return {16'(DEPTH - mq.size()), 16'h0000};
  endfunction

  function automatic int clip(input int req, input int room);
    return (req > room) ? room : req;
  endfunction

  task automatic check_outputs();
    cmp("tx_valid", 32'(tx_valid), 32'(mq.size() != 0));
    if (mq.size() != 0) cmp("tx_data", 32'(tx_data), 32'(mq[0]));
    cmp("xfer_status", xfer_status, exp_free());
    cmp("int_status", int_status, m_st);
    cmp("irq", 32'(irq), 32'(|(m_st & m_en)));
  endtask

  task automatic step(input bit bw, input bit ww, input logic [31:0] d, input bit rdy,
                      input bit cw, input logic [31:0] cd,
                      input bit ew, input logic [31:0] ed);
    int pre, req, acc;
    logic [31:0] setv, clr;
    check_outputs();
    wr_byte_we = bw; wr_word_we = ww; wr_data = d; tx_ready = rdy;
    int_clr_we = cw; int_clr_data = cd; int_en_we = ew; int_en_data = ed;
    pre = mq.size();
    req = ww ? 4 : (bw ? 1 : 0);
    acc = clip(req, DEPTH - pre);
    setv = '0;
    if (pre == 0) setv[9] = 1'b1;
    if (pre == DEPTH) setv[10] = 1'b1;
    if (acc != req) setv[11] = 1'b1;
    clr = cw ? cd : 32'd0;
    m_st = ((m_st & ~clr) | setv) & IMPL;
    if (ew) m_en = ed & IMPL;
    if (rdy && pre > 0) void'(mq.pop_front());
    for (int i = 0; i < acc; i++) mq.push_back(d[8*i +: 8]);
    @(posedge clk);
    @(negedge clk);
    wr_byte_we = 0; wr_word_we = 0; int_clr_we = 0; int_en_we = 0;
  endtask

  task automatic idle(input bit rdy);
    step(0, 0, 32'd0, rdy, 0, 32'd0, 0, 32'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp("tx_valid", 32'(tx_valid), 32'd0);
    cmp("xfer_status", xfer_status, 32'h0040_0000);
    cmp("int_status", int_status, 32'd0);
    cmp("irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    m_st = IMPL & 32'h200; // first edge after reset saw an empty queue (R7)
    // R2: byte port keeps only the low byte
    tag = "R2";
    step(1, 0, 32'hDEAD_BE5A, 0, 0, 0, 0, 0);
    cmp("byte_only", 32'(tx_data), 32'h5A);
    cmp("free_after_byte", xfer_status, 32'h003F_0000);
    // R3: word port LSB first, word wins over byte strobe
    tag = "R3";
    step(0, 1, 32'h4433_2211, 0, 0, 0, 0, 0);
    step(1, 1, 32'h8877_6655, 0, 0, 0, 0, 0);
    cmp("free_after_words", xfer_status, 32'h0037_0000);
    for (int i = 0; i < 10; i++) idle(1);
    // R7: empty sticky, clear loses to set, full sets
    tag = "R7";
    idle(0);
    step(0, 0, 0, 0, 1, 32'h200, 0, 0);
    cmp("empty_reasserted", 32'(int_status[9]), 32'd1);
    for (int i = 0; i < DEPTH / 4; i++) step(0, 1, 32'hA0A1_A2A3 + 32'(i), 0, 0, 0, 0, 0);
    idle(0);
    cmp("full_bit", 32'(int_status[10]), 32'd1);
    // R6: push into a full queue with a pop in the same cycle
    tag = "R6";
    step(0, 1, 32'hCAFE_F00D, 1, 0, 0, 0, 0);
    cmp("ovr_bit", 32'(int_status[11]), 32'd1);
    cmp("free_after_drop", xfer_status, 32'h0001_0000);
    idle(1);
    step(0, 1, 32'h1357_9BDF, 0, 0, 0, 0, 0);
    cmp("partial_accept", xfer_status, 32'h0000_0000);
    // R8: write-1-to-clear, zeros leave bits alone
    tag = "R8";
    step(0, 0, 0, 0, 1, 32'h0000_0800, 0, 0);
    cmp("ovr_cleared", 32'(int_status[11]), 32'd0);
    cmp("full_kept", 32'(int_status[10]), 32'd1);
    step(0, 0, 0, 0, 1, 32'hFFFF_F1FF, 0, 0);
    // R9: enable masking
    tag = "R9";
    step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_F1FF);
    cmp("irq_unimpl_enable", 32'(irq), 32'd0);
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0400);
    cmp("irq_full_enabled", 32'(irq), 32'd1);
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0800);
    cmp("irq_ovr_masked", 32'(irq), 32'd0);
    // R4 R5: random mix
    tag = "R4 R5";
    for (int i = 0; i < 4000; i++) begin
      bit bw, ww, rdy, cw, ew;
      logic [31:0] d, cd, ed;
      int r;
      r = int'($urandom_range(0, 99));
      ww = (r < 35);
      bw = (r >= 30 && r < 55);
      rdy = ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 30 : 80));
      cw = ($urandom_range(0, 9) == 0);
      ew = ($urandom_range(0, 19) == 0);
      d = $urandom();
      cd = $urandom();
      ed = $urandom();
      step(bw, ww, d, rdy, cw, cd, ew, ed);
    end
    check_outputs();
    done = 1;
    summary();
    $finish;
  end

endmodule